// File: doc/BRIEF.md
# One-Time-Programmable Register Bank with Lock Words

This block models the protection-register area of a parallel flash-style memory. It holds a bank of one-time-programmable (OTP) 16-bit words and two lock words that guard them. The first 128-bit register has two halves. Its lower half carries a factory-written unique identifier that can never be changed. Its upper half is free for the user. Sixteen further 128-bit registers follow, and each one has its own lock bit.

A bus master programs a word with a two-cycle command. The first write carries the setup code to the target word address. The second write carries 16 bits of data to the same address. Programming can only move bits from 1 to 0. The block checks the address and the lock state of the target. It either clears the bits in the word or reports the fault in the status byte. In both cases the status byte then shows busy for a fixed number of cycles. The master reads the OTP and lock words back through a separate combinational read port.

Top module: `otp_bank`

## Requirements
- R1: After reset, status_o reads 0x80. Lock word 0 (address 0x080) reads 0xFFFE and lock word 1 (0x089) reads 0xFFFF. Identifier words 0x081..0x084 read ID_VALUE[15:0], [31:16], [47:32] and [63:48] in that order. Every other OTP word reads 0xFFFF, and any address outside 0x080..0x109 reads 0xFFFF.
- R2: A write of 0x00C0 to address A while idle arms the block. The next write with data D to the same address A sets the word at A to its old value AND D. No other word changes.
- R3: If the armed address is outside 0x080..0x109, the data cycle sets program error (status bit 4) and changes nothing.
- R4: A data cycle to a word whose region is locked sets both program error (bit 4) and lock error (bit 1) and leaves the word unchanged. The identifier half 0x081..0x084 is always locked.
- R5: Lock words are programmed by the same AND sequence at 0x080 and 0x089. A lock bit reads 0 when it is set. Bit 1 of lock word 0 guards 0x085..0x088. Bit k of lock word 1 guards 0x08A+8k..0x08A+8k+7.
- R6: Lock bits never return to 1. Bit 0 of lock word 0 stays 0 at all times.
- R7: If the data cycle's address differs from the armed address, program error is set, nothing is programmed, and the block returns to idle.
- R8: After every data cycle, status bit 7 reads 0 for exactly BUSY_CYC clock cycles and then 1. All writes made while busy are ignored.
- R9: Program and lock error bits stay set until an idle, not-busy write of 0x0050 clears both of them.
- R10: While idle, a write whose data is neither 0x00C0 nor 0x0050 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | 16 | Command code or program data |
| rd_addr_i | input | ADDR_W | Word address for readback |
| rd_data_o | output | 16 | Combinational readback of OTP or lock word |
| status_o | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error, others 0 |

## Verification
Some properties are checked on every clock edge: that no stored or lock bit ever rises, that words hold still outside data cycles, and that faulting data cycles set the correct error bits without changing storage. The same per-cycle checks cover the sticky error bits, the loading of the busy counter, and the rule that idle writes other than the two command codes are ignored. Other behaviour needs the bench's sequences to show it. These include the AND result of two program passes over each word, the mapping of each lock bit to its eight-word region across the whole sweep, the exact busy length seen at the ports, and a clear or setup issued while busy having no lasting effect.

// File: rtl/otp_pkg.sv
package otp_pkg;
   localparam int WORD_W      = 16;
   localparam int FIRST_WORDS = 8;
   localparam int HALF_WORDS  = FIRST_WORDS / 2;
   localparam int GUARD_W     = 5;
   localparam int SR_READY    = 7;
   localparam int SR_PERR     = 4;
   localparam int SR_LERR     = 1;

   typedef logic [WORD_W-1:0] otp_word_t;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_LOCK = 2'd1,
      TGT_DATA = 2'd2
   } otp_tgt_e;
endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec
   import otp_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int BASE      = 128,
   parameter int EXT_REGS  = 16,
   parameter int EXT_WORDS = 8,
   parameter int IDX_W     = 8
)(
   input  logic [ADDR_W-1:0] addr_i,
   output otp_tgt_e          tgt_o,
   output logic              lock_sel_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int LOCK0_A = BASE;
   localparam int FIRST_A = BASE + 1;
   localparam int LOCK1_A = FIRST_A + FIRST_WORDS;
   localparam int EXT_A   = LOCK1_A + 1;
   localparam int EXT_END = EXT_A + EXT_REGS * EXT_WORDS;

   always_comb begin
      int a;
      a          = int'(addr_i);
      tgt_o      = TGT_NONE;
      lock_sel_o = 1'b0;
      idx_o      = '0;
      if (a == LOCK0_A) begin
         tgt_o = TGT_LOCK;
      end else if (a == LOCK1_A) begin
         tgt_o      = TGT_LOCK;
         lock_sel_o = 1'b1;
      end else if (a >= FIRST_A && a < LOCK1_A) begin
         tgt_o = TGT_DATA;
         idx_o = IDX_W'(a - FIRST_A);
      end else if (a >= EXT_A && a < EXT_END) begin
         tgt_o = TGT_DATA;
         idx_o = IDX_W'(a - EXT_A + FIRST_WORDS);
      end
   end
endmodule

// File: rtl/otp_guard_sel.sv
module otp_guard_sel
   import otp_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int EXT_WORDS = 8
)(
   input  logic [IDX_W-1:0] idx_i,
   input  otp_word_t        lock0_i,
   input  otp_word_t        lock1_i,
   output logic             locked_o
);
   localparam int EXT_SH = $clog2(EXT_WORDS);

   logic [2*WORD_W-1:0]  guard_vec;
   logic [GUARD_W-1:0]   guard_idx;

   assign guard_vec = {lock1_i, lock0_i};

   always_comb begin
      int i;
      i = int'(idx_i);
      if (i < HALF_WORDS)       guard_idx = GUARD_W'(0);
      else if (i < FIRST_WORDS) guard_idx = GUARD_W'(1);
      else                      guard_idx = GUARD_W'(WORD_W + ((i - FIRST_WORDS) >> EXT_SH));
   end

   // a lock bit that reads 0 is set
   assign locked_o = ~guard_vec[guard_idx];
endmodule

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
   parameter  int CYCLES = 8,
   localparam int CNT_W  = $clog2(CYCLES + 1)
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni)             cnt_o <= '0;
      else if (start_i)        cnt_o <= CNT_W'(CYCLES);
      else if (cnt_o != '0)    cnt_o <= cnt_o - 1'b1;
   end

   assign busy_o = (cnt_o != '0);
endmodule

// File: rtl/otp_bank.sv
module otp_bank
   import otp_pkg::*;
#(
   parameter int          ADDR_W     = 10,
   parameter int          BASE       = 128,
   parameter int          EXT_REGS   = 16,
   parameter int          EXT_WORDS  = 8,
   parameter int          BUSY_CYC   = 8,
   parameter logic [15:0] SETUP_CODE = 16'h00C0,
   parameter logic [15:0] CLEAR_CODE = 16'h0050,
   parameter logic [63:0] ID_VALUE   = 64'h0123_4567_89AB_CDEF
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [15:0]       wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [15:0]       rd_data_o,
   output logic [7:0]        status_o
);
   localparam int DATA_WORDS = FIRST_WORDS + EXT_REGS * EXT_WORDS;
   localparam int IDX_W      = $clog2(DATA_WORDS);
   localparam int CNT_W      = $clog2(BUSY_CYC + 1);
   localparam int TOP_A      = BASE + FIRST_WORDS + 1 + EXT_REGS * EXT_WORDS;

   if (EXT_REGS < 1 || EXT_REGS > WORD_W) begin : g_bad_regs
      $error("EXT_REGS must lie in 1..16");
   end
   if (EXT_WORDS < 1 || (EXT_WORDS & (EXT_WORDS - 1)) != 0) begin : g_bad_words
      $error("EXT_WORDS must be a power of two");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end
   if (TOP_A >= (1 << ADDR_W)) begin : g_bad_addr
      $error("OTP space does not fit in ADDR_W");
   end
   if ($bits(ID_VALUE) != HALF_WORDS * WORD_W) begin : g_bad_id
      $error("ID_VALUE width must match the identifier half");
   end

   logic                            armed_q;
   logic [ADDR_W-1:0]               arm_addr_q;
   otp_word_t                       lock0_q, lock1_q;
   logic [DATA_WORDS-1:0][WORD_W-1:0] data_q;
   logic                            perr_q, lerr_q;
   logic                            busy;
   logic [CNT_W-1:0]                busy_cnt;

   otp_tgt_e                        w_tgt, r_tgt;
   logic                            w_lsel, r_lsel;
   logic [IDX_W-1:0]                w_idx, r_idx;
   logic                            w_locked;

   otp_addr_dec #(
      .ADDR_W(ADDR_W), .BASE(BASE), .EXT_REGS(EXT_REGS),
      .EXT_WORDS(EXT_WORDS), .IDX_W(IDX_W)
   ) wdec_i (
      .addr_i(wr_addr_i), .tgt_o(w_tgt), .lock_sel_o(w_lsel), .idx_o(w_idx)
   );

   otp_addr_dec #(
      .ADDR_W(ADDR_W), .BASE(BASE), .EXT_REGS(EXT_REGS),
      .EXT_WORDS(EXT_WORDS), .IDX_W(IDX_W)
   ) rdec_i (
      .addr_i(rd_addr_i), .tgt_o(r_tgt), .lock_sel_o(r_lsel), .idx_o(r_idx)
   );

   otp_guard_sel #(.IDX_W(IDX_W), .EXT_WORDS(EXT_WORDS)) guard_i (
      .idx_i(w_idx), .lock0_i(lock0_q), .lock1_i(lock1_q), .locked_o(w_locked)
   );

   logic accept, clear_hit, setup_hit, data_cyc, addr_ok;
   logic lock_wr, word_wr, lerr_set, perr_set;

   assign accept    = wr_en_i && !busy;
   assign setup_hit = accept && !armed_q && (wr_data_i == SETUP_CODE);
   assign clear_hit = accept && !armed_q && (wr_data_i == CLEAR_CODE);
   assign data_cyc  = accept && armed_q;
   assign addr_ok   = (wr_addr_i == arm_addr_q);
   assign lock_wr   = data_cyc && addr_ok && (w_tgt == TGT_LOCK);
   assign word_wr   = data_cyc && addr_ok && (w_tgt == TGT_DATA) && !w_locked;
   assign lerr_set  = data_cyc && addr_ok && (w_tgt == TGT_DATA) && w_locked;
   assign perr_set  = data_cyc && (!addr_ok || (w_tgt == TGT_NONE) || lerr_set);

   otp_busy_timer #(.CYCLES(BUSY_CYC)) timer_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(data_cyc),
      .busy_o(busy), .cnt_o(busy_cnt)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         armed_q    <= 1'b0;
         arm_addr_q <= '0;
         perr_q     <= 1'b0;
         lerr_q     <= 1'b0;
         lock0_q    <= 16'hFFFE;
         lock1_q    <= 16'hFFFF;
      end else begin
         if (setup_hit) begin
            armed_q    <= 1'b1;
            arm_addr_q <= wr_addr_i;
         end else if (data_cyc) begin
            armed_q    <= 1'b0;
         end
         if (clear_hit) begin
            perr_q <= 1'b0;
            lerr_q <= 1'b0;
         end else begin
            perr_q <= perr_q | perr_set;
            lerr_q <= lerr_q | lerr_set;
         end
         if (lock_wr && !w_lsel) lock0_q <= lock0_q & wr_data_i;
         if (lock_wr &&  w_lsel) lock1_q <= lock1_q & wr_data_i;
      end
   end

   for (genvar gw = 0; gw < DATA_WORDS; gw++) begin : g_word
      if (gw < HALF_WORDS) begin : g_id
         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               data_q[gw] <= ID_VALUE[gw*WORD_W +: WORD_W];
            else if (word_wr && (w_idx == IDX_W'(gw)))
               data_q[gw] <= data_q[gw] & wr_data_i;
         end
      end else begin : g_usr
         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               data_q[gw] <= '1;
            else if (word_wr && (w_idx == IDX_W'(gw)))
               data_q[gw] <= data_q[gw] & wr_data_i;
         end
      end
   end

   always_comb begin
      case (r_tgt)
         TGT_LOCK: rd_data_o = r_lsel ? lock1_q : lock0_q;
         TGT_DATA: rd_data_o = data_q[r_idx];
         default:  rd_data_o = 16'hFFFF;
      endcase
   end

   assign status_o = {!busy, 2'b00, perr_q, 2'b00, lerr_q, 1'b0};
endmodule

// File: rtl/otp_bank_chk.sv
module otp_bank_chk
   import otp_pkg::*;
#(
   parameter int          ADDR_W     = 10,
   parameter int          DATA_WORDS = 136,
   parameter int          BUSY_CYC   = 8,
   parameter logic [15:0] SETUP_CODE = 16'h00C0,
   parameter logic [15:0] CLEAR_CODE = 16'h0050,
   localparam int         CNT_W      = $clog2(BUSY_CYC + 1)
)(
   input logic                              clk_i,
   input logic                              rst_ni,
   input logic                              wr_en_i,
   input logic [ADDR_W-1:0]                 wr_addr_i,
   input logic [15:0]                       wr_data_i,
   input logic [7:0]                        status_i,
   input logic                              armed_i,
   input logic [ADDR_W-1:0]                 arm_addr_i,
   input logic                              busy_i,
   input logic [CNT_W-1:0]                  cnt_i,
   input otp_tgt_e                          w_tgt_i,
   input logic                              w_locked_i,
   input logic [DATA_WORDS-1:0][WORD_W-1:0] data_i,
   input otp_word_t                         lock0_i,
   input otp_word_t                         lock1_i
);
   logic [DATA_WORDS*WORD_W-1:0] flat;
   logic                         dcyc, same;

   assign flat = data_i;
   assign dcyc = wr_en_i && !busy_i && armed_i;
   assign same = (wr_addr_i == arm_addr_i);

   p_id_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock0_i[0] == 1'b0);

   p_lock_mono_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (((lock0_i & ~$past(lock0_i)) == '0) && ((lock1_i & ~$past(lock1_i)) == '0)));

   p_word_mono_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((flat & ~$past(flat)) == '0));

   p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dcyc |=> $stable(flat));

   p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dcyc && same && (w_tgt_i == TGT_NONE) |=> status_i[SR_PERR] && $stable(flat));

   p_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dcyc && same && (w_tgt_i == TGT_DATA) && w_locked_i
      |=> status_i[SR_PERR] && status_i[SR_LERR] && $stable(flat));

   p_mismatch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dcyc && !same |=> status_i[SR_PERR] && $stable(flat) && $stable(lock0_i)
                        && $stable(lock1_i) && !armed_i);

   p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dcyc |=> !status_i[SR_READY] && (cnt_i == CNT_W'(BUSY_CYC)));

   p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i <= CNT_W'(BUSY_CYC));

   p_busy_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |-> !armed_i);

   p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_i[SR_PERR] && !(wr_en_i && !busy_i && !armed_i && (wr_data_i == CLEAR_CODE))
      |=> status_i[SR_PERR]);

   p_idle_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !busy_i && !armed_i && (wr_data_i != SETUP_CODE) && (wr_data_i != CLEAR_CODE)
      |=> $stable(flat) && $stable(lock0_i) && $stable(lock1_i) && !armed_i
          && $stable(status_i[SR_PERR]) && $stable(status_i[SR_LERR]));
endmodule

bind otp_bank otp_bank_chk #(
   .ADDR_W(ADDR_W), .DATA_WORDS(DATA_WORDS), .BUSY_CYC(BUSY_CYC),
   .SETUP_CODE(SETUP_CODE), .CLEAR_CODE(CLEAR_CODE)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
   .wr_data_i(wr_data_i), .status_i(status_o), .armed_i(armed_q),
   .arm_addr_i(arm_addr_q), .busy_i(busy), .cnt_i(busy_cnt), .w_tgt_i(w_tgt),
   .w_locked_i(w_locked), .data_i(data_q), .lock0_i(lock0_q), .lock1_i(lock1_q)
);

// File: tb/otp_bank_tb_top.sv
module otp_bank_tb_top;
   localparam int          BUSY  = 8;
   localparam logic [15:0] SETUP = 16'h00C0;
   localparam logic [15:0] CLEAR = 16'h0050;
   localparam logic [63:0] ID    = 64'h0123_4567_89AB_CDEF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [9:0]  wr_addr, rd_addr;
   logic [15:0] wr_data, rd_data;
   logic [7:0]  status;

   always #4 clk = ~clk;

   otp_bank dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .status_o(status)
   );

   int checks = 0;
   int fails  = 0;
   logic [15:0] mdl [0:1023];
   bit m_perr, m_lerr;

   task automatic chk16(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic int kind(input int a);
      if (a == 'h80 || a == 'h89) return 1;
      if ((a >= 'h81 && a <= 'h88) || (a >= 'h8A && a <= 'h109)) return 2;
      return 0;
   endfunction

   function automatic bit is_locked(input int a);
      if (a <= 'h84) return !mdl['h80][0];
      if (a <= 'h88) return !mdl['h80][1];
      return !mdl['h89][(a - 'h8A) >> 3];
   endfunction

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 10'(a);
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!status[7]) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic model_data(input int as, input int ad, input logic [15:0] d);
      if (as != ad || kind(ad) == 0) m_perr = 1'b1;
      else if (kind(ad) == 1) mdl[ad] = mdl[ad] & d;
      else if (is_locked(ad)) begin m_perr = 1'b1; m_lerr = 1'b1; end
      else mdl[ad] = mdl[ad] & d;
   endtask

   task automatic prog(input int as, input int ad, input logic [15:0] d, output int n);
      wr(as, SETUP);
      wr(ad, d);
      model_data(as, ad, d);
      wait_ready(n);
   endtask

   task automatic chk_status(input string req);
      chk16(req, "status", {8'h00, status}, {8'h00, 1'b1, 2'b00, m_perr, 2'b00, m_lerr, 1'b0});
   endtask

   task automatic clr();
      wr(0, CLEAR);
      m_perr = 1'b0;
      m_lerr = 1'b0;
   endtask

   task automatic chk_all(input string req);
      for (int a = 'h7C; a <= 'h10D; a++) begin
         rd_addr = 10'(a);
         #1;
         chk16(req, $sformatf("word %h", a), rd_data, mdl[a]);
      end
      rd_addr = 10'h3FF;
      #1;
      chk16(req, "word 3ff", rd_data, 16'hFFFF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      int n;
      for (int a = 0; a < 1024; a++) mdl[a] = 16'hFFFF;
      mdl['h80] = 16'hFFFE;
      for (int i = 0; i < 4; i++) mdl['h81 + i] = ID[16*i +: 16];
      m_perr = 1'b0;
      m_lerr = 1'b0;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset contents and status
      chk_status("R1");
      chk_all("R1");

      // R2/R4: first pass over every OTP word, ID half locked
      for (int a = 'h81; a <= 'h109; a++) begin
         if (a == 'h89) continue;
         prog(a, a, ~(16'h0001 << (a % 16)), n);
         chk16("R8", "busy length", 16'(n), 16'(BUSY));
         chk_status((a <= 'h84) ? "R4" : "R2");
         if (m_perr) begin
            clr();
            chk_status("R9");
         end
      end
      chk_all("R2");

      // R2: second pass, AND with a new pattern
      for (int a = 'h85; a <= 'h109; a++) begin
         if (a == 'h89) continue;
         prog(a, a, 16'h5A5A ^ 16'(a), n);
      end
      chk_status("R2");
      chk_all("R2");

      // R3: addresses outside the OTP space
      prog('h7F, 'h7F, 16'h0000, n);
      chk_status("R3");
      clr();
      prog('h10A, 'h10A, 16'h0000, n);
      chk_status("R3");
      clr();
      prog('h3FF, 'h3FF, 16'h0000, n);
      chk_status("R3");
      chk_all("R3");
      clr();

      // R7: data cycle to a different address aborts
      prog('h90, 'h91, 16'h0000, n);
      chk_status("R7");
      clr();
      wr('h91, 16'h0000);
      chk_all("R7");

      // R10: idle writes that are not commands do nothing
      wr('h92, 16'h00C1);
      wr('h92, 16'h0000);
      chk_status("R10");
      chk_all("R10");

      // R8: setup issued while busy is ignored
      wr('h93, SETUP);
      wr('h93, 16'hFFFF);
      wr('h94, SETUP);
      wait_ready(n);
      wr('h94, 16'h0000);
      chk_status("R8");
      chk_all("R8");

      // R9: clear issued while busy is ignored
      wr('h7F, SETUP);
      wr('h7F, 16'h0000);
      m_perr = 1'b1;
      wr('h00, CLEAR);
      wait_ready(n);
      chk_status("R9");
      clr();
      chk_status("R9");

      // R5: lock user half and three extension registers
      prog('h80, 'h80, 16'hFFFD, n);
      chk_status("R5");
      prog('h86, 'h86, 16'h0000, n);
      chk_status("R5");
      clr();
      prog('h89, 'h89, ~16'h8021, n);
      chk_status("R5");
      for (int a = 'h8A; a <= 'h109; a++) begin
         prog(a, a, 16'h0000, n);
         chk_status("R5");
         if (m_perr) clr();
      end
      chk_all("R5");

      // R6: lock bits cannot be restored
      prog('h80, 'h80, 16'hFFFF, n);
      prog('h89, 'h89, 16'hFFFF, n);
      chk_status("R6");
      chk_all("R6");

      summary();
      $finish;
   end
endmodule